// File: doc/BRIEF.md
# Single-Line Surface Read Cache

The block holds one 4 KiB window of a byte-addressed pixel surface so that a pixel access port can read neighbouring pixels without going back to memory every time. A read request carries a byte offset and a size code. When the 4 KiB-aligned window holding that offset is already resident, the value comes straight from the local buffer. When it is not resident, the block first fetches the whole aligned window from backing memory over a 32-bit read port, and only then answers.

Writes are not cached. Each legal write goes straight to memory as one 32-bit beat with byte enables, and the resident window is dropped in the same step, so the next read refetches. A separate clear input drops the window without any memory traffic. This is used when the surface is released. One size code serves 32-bit colour surfaces that carry no alpha. A read with it returns the word with its top byte forced high, and a write with it touches only the lower three bytes.

Top module: `span_line_cache`

## Requirements
- R1: After reset, req_ready is 1 and resp_valid, mrd_valid and mwr_valid are 0. The first read after reset always misses.
- R2: The line tag is the request offset with its low 12 bits cleared. A read whose tag equals the resident tag, while the line is valid, is answered with no memory read beat.
- R3: A read miss issues exactly 1024 read beats on mrd_addr. They start at the aligned tag and rise by 4 each beat, and all of them complete before the response.
- R4: Read data is little-endian, taken at the offset's low 12 bits and zero-extended. Size code 0 returns 1 byte, code 1 returns 2 bytes, and code 2 returns 4 bytes.
- R5: A read with size code 3 returns the 32-bit word at the offset with bits 31:24 forced to 8'hFF.
- R6: Every accepted legal write issues one write beat. The beat carries mwr_addr equal to the offset with its low 2 bits cleared, and the write data shifted up by 8 times the offset's low 2 bits. The write invalidates the line, so the next read of that line misses.
- R7: The write byte enables are 4'b0001 shifted by the offset's low 2 bits for code 0, 4'b0011 shifted for code 1, 4'b1111 for code 2 and 4'b0111 for code 3. Code 3 therefore leaves byte 3 of the word unchanged.
- R8: A one-cycle pulse on clear invalidates the line without any memory beat. The next read refetches the line.
- R9: A request is misaligned when it has code 1 with offset bit 0 set, or code 2 or 3 with offset bits 1:0 not zero. Such a request returns resp_err = 1 with no memory beat, and the resident line stays valid.
- R10: req_ready is 1 only while the block is idle. Each accepted request produces exactly one resp_valid pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Drop the resident line, no memory traffic |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 word without alpha |
| req_addr | input | ADDR_W | Byte offset into the surface |
| req_wdata | input | 32 | Write value, right-aligned |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_err | output | 1 | Misaligned request |
| resp_rdata | output | 32 | Read value, zero when not a good read |
| mrd_valid | output | 1 | Memory read address valid |
| mrd_ready | input | 1 | Memory accepts read address |
| mrd_addr | output | ADDR_W | Word-aligned byte address of the read beat |
| mrd_rvalid | input | 1 | Read data beat, in request order |
| mrd_rdata | input | 32 | Read data |
| mwr_valid | output | 1 | Write beat valid |
| mwr_ready | input | 1 | Memory accepts write beat |
| mwr_addr | output | ADDR_W | Word-aligned byte address of the write |
| mwr_data | output | 32 | Lane-placed write data |
| mwr_be | output | 4 | Byte enables |

## Verification
Some properties are checked on every cycle. A fill has either zero or a full line of beats, its first address is line-aligned, and errored requests cause no memory beats. A legal write makes exactly one write beat that holds steady under back-pressure. No-alpha reads always carry a high top byte, byte reads are zero-extended, and a response never overlaps readiness. Other behaviour shows only in the bench's directed scenarios. These cover hit versus miss after a tag change, invalidation by writes and by clear, the exact byte-enable patterns, a preserved top byte after a no-alpha write, and the survival of the line across rejected requests. They also check that the returned values match a memory shadow that the bench updates by the requirement rules.

// File: rtl/span_cache_pkg.sv
package span_cache_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOK,
      ST_FILL,
      ST_READ,
      ST_WRITE,
      ST_RESP
   } cache_state_e;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;
   localparam logic [1:0] SZ_RGBX = 2'd3;

   function automatic logic is_misaligned(input logic [1:0] size, input logic [1:0] lane);
      case (size)
         SZ_BYTE: is_misaligned = 1'b0;
         SZ_HALF: is_misaligned = lane[0];
         default: is_misaligned = (lane != 2'd0);
      endcase
   endfunction

   function automatic logic [3:0] lane_enables(input logic [1:0] size, input logic [1:0] lane);
      case (size)
         SZ_BYTE: lane_enables = 4'b0001 << lane;
         SZ_HALF: lane_enables = 4'b0011 << lane;
         SZ_WORD: lane_enables = 4'b1111;
         default: lane_enables = 4'b0111;
      endcase
   endfunction

endpackage

// File: rtl/scache_tag.sv
module scache_tag #(
   parameter int TAG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             drop,
   input  logic             load,
   input  logic [TAG_W-1:0] load_tag,
   input  logic [TAG_W-1:0] probe_tag,
   output logic             hit
);

   logic             line_ok;
   logic [TAG_W-1:0] line_tag;

   // drop wins over a load in the same cycle: the line stays unusable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_ok  <= 1'b0;
         line_tag <= '0;
      end else if (drop) begin
         line_ok  <= 1'b0;
      end else if (load) begin
         line_ok  <= 1'b1;
         line_tag <= load_tag;
      end
   end

   assign hit = line_ok && (line_tag == probe_tag);

endmodule

// File: rtl/scache_fill.sv
module scache_fill #(
   parameter int ADDR_W = 16,
   parameter int TAG_W  = 4,
   parameter int IDX_W  = 10,
   parameter int LANE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [TAG_W-1:0]  base_tag,
   output logic              mrd_valid,
   input  logic              mrd_ready,
   output logic [ADDR_W-1:0] mrd_addr,
   input  logic              mrd_rvalid,
   output logic              buf_we,
   output logic [IDX_W-1:0]  buf_widx,
   output logic              done
);

   localparam int WORDS = 1 << IDX_W;

   logic             active;
   logic [IDX_W:0]   issued;
   logic [IDX_W-1:0] received;
   logic [TAG_W-1:0] cur_tag;
   logic             last_beat;

   assign last_beat = active && mrd_rvalid && (received == IDX_W'(WORDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         issued   <= '0;
         received <= '0;
         cur_tag  <= '0;
      end else if (start) begin
         active   <= 1'b1;
         issued   <= '0;
         received <= '0;
         cur_tag  <= base_tag;
      end else if (active) begin
         if (mrd_valid && mrd_ready) issued <= issued + 1'b1;
         if (mrd_rvalid) received <= received + 1'b1;
         if (last_beat) active <= 1'b0;
      end
   end

   assign mrd_valid = active && !issued[IDX_W];
   assign mrd_addr  = {cur_tag, issued[IDX_W-1:0], {LANE_W{1'b0}}};
   assign buf_we    = active && mrd_rvalid;
   assign buf_widx  = received;
   assign done      = last_beat;

endmodule

// File: rtl/scache_buf.sv
module scache_buf #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 10
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [IDX_W-1:0]  ridx,
   output logic [DATA_W-1:0] rdata
);

   localparam int WORDS = 1 << IDX_W;

   logic [DATA_W-1:0] store [WORDS];

   always_ff @(posedge clk) begin
      if (we) store[widx] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (re) rdata <= store[ridx];
   end

endmodule

// File: rtl/scache_lane.sv
module scache_lane
   import span_cache_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [1:0]          size,
   input  logic [1:0]          lane,
   input  logic [DATA_W-1:0]   rd_word,
   input  logic [DATA_W-1:0]   wr_value,
   output logic [DATA_W-1:0]   rd_value,
   output logic [DATA_W-1:0]   wr_data,
   output logic [DATA_W/8-1:0] wr_be
);

   localparam int NLANE = DATA_W / 8;

   logic [DATA_W-1:0] rd_shift;
   logic [DATA_W-1:0] wr_shift;

   // byte k of the shifted read word is byte k+lane of the stored word
   for (genvar k = 0; k < NLANE; k++) begin : g_rd_lane
      always_comb begin
         rd_shift[8*k +: 8] = 8'h00;
         for (int s = 0; s < NLANE; s++) begin
            if (32'(s) == 32'(lane) + k) rd_shift[8*k +: 8] = rd_word[8*s +: 8];
         end
      end
   end

   always_comb begin
      case (size)
         SZ_BYTE: rd_value = {{(DATA_W-8){1'b0}},  rd_shift[7:0]};
         SZ_HALF: rd_value = {{(DATA_W-16){1'b0}}, rd_shift[15:0]};
         SZ_WORD: rd_value = rd_word;
         default: rd_value = {8'hFF, rd_word[DATA_W-9:0]};
      endcase
   end

   assign wr_shift = wr_value << {lane, 3'b000};
   assign wr_data  = wr_shift;
   assign wr_be    = lane_enables(size, lane);

endmodule

// File: rtl/span_line_cache.sv
module span_line_cache
   import span_cache_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int LINE_BYTES = 4096,
   parameter int DATA_W     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              resp_valid,
   output logic              resp_err,
   output logic [31:0]       resp_rdata,
   output logic              mrd_valid,
   input  logic              mrd_ready,
   output logic [ADDR_W-1:0] mrd_addr,
   input  logic              mrd_rvalid,
   input  logic [31:0]       mrd_rdata,
   output logic              mwr_valid,
   input  logic              mwr_ready,
   output logic [ADDR_W-1:0] mwr_addr,
   output logic [31:0]       mwr_data,
   output logic [3:0]        mwr_be
);

   localparam int BYTES_W = DATA_W / 8;
   localparam int LANE_W  = $clog2(BYTES_W);
   localparam int OFS_W   = $clog2(LINE_BYTES);
   localparam int IDX_W   = OFS_W - LANE_W;
   localparam int TAG_W   = ADDR_W - OFS_W;

   if (DATA_W != 32) begin : g_bad_width
      $error("span_line_cache: DATA_W must be 32");
   end
   if ((1 << OFS_W) != LINE_BYTES) begin : g_bad_line
      $error("span_line_cache: LINE_BYTES must be a power of two");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr
      $error("span_line_cache: ADDR_W must exceed the line offset width");
   end

   cache_state_e      state;
   logic              r_write;
   logic [1:0]        r_size;
   logic [ADDR_W-1:0] r_addr;
   logic [31:0]       r_wdata;
   logic              r_err;

   logic              hit;
   logic              bad;
   logic              look_miss;
   logic              look_write;
   logic              fill_done;
   logic              buf_we;
   logic [IDX_W-1:0]  buf_widx;
   logic [31:0]       buf_word;
   logic [31:0]       fmt_word;

   assign bad        = is_misaligned(r_size, r_addr[1:0]);
   assign look_miss  = (state == ST_LOOK) && !bad && !r_write && !hit;
   assign look_write = (state == ST_LOOK) && !bad && r_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         r_write <= 1'b0;
         r_size  <= SZ_BYTE;
         r_addr  <= '0;
         r_wdata <= '0;
         r_err   <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (req_valid) begin
               r_write <= req_write;
               r_size  <= req_size;
               r_addr  <= req_addr;
               r_wdata <= req_wdata;
               r_err   <= 1'b0;
               state   <= ST_LOOK;
            end
            ST_LOOK: begin
               if (bad) begin
                  r_err <= 1'b1;
                  state <= ST_RESP;
               end else if (r_write) begin
                  state <= ST_WRITE;
               end else if (hit) begin
                  state <= ST_READ;
               end else begin
                  state <= ST_FILL;
               end
            end
            ST_FILL:  if (fill_done) state <= ST_READ;
            ST_READ:  state <= ST_RESP;
            ST_WRITE: if (mwr_ready) state <= ST_RESP;
            ST_RESP:  state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   scache_tag #(.TAG_W(TAG_W)) u_tag (
      .clk       (clk),
      .rst_n     (rst_n),
      .drop      (clear || look_write),
      .load      (look_miss),
      .load_tag  (r_addr[ADDR_W-1:OFS_W]),
      .probe_tag (r_addr[ADDR_W-1:OFS_W]),
      .hit       (hit)
   );

   scache_fill #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .LANE_W(LANE_W)) u_fill (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (look_miss),
      .base_tag   (r_addr[ADDR_W-1:OFS_W]),
      .mrd_valid  (mrd_valid),
      .mrd_ready  (mrd_ready),
      .mrd_addr   (mrd_addr),
      .mrd_rvalid (mrd_rvalid),
      .buf_we     (buf_we),
      .buf_widx   (buf_widx),
      .done       (fill_done)
   );

   scache_buf #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_buf (
      .clk   (clk),
      .we    (buf_we),
      .widx  (buf_widx),
      .wdata (mrd_rdata),
      .re    (state == ST_READ),
      .ridx  (r_addr[OFS_W-1:LANE_W]),
      .rdata (buf_word)
   );

   scache_lane #(.DATA_W(DATA_W)) u_lane (
      .size     (r_size),
      .lane     (r_addr[1:0]),
      .rd_word  (buf_word),
      .wr_value (r_wdata),
      .rd_value (fmt_word),
      .wr_data  (mwr_data),
      .wr_be    (mwr_be)
   );

   assign req_ready  = (state == ST_IDLE);
   assign resp_valid = (state == ST_RESP);
   assign resp_err   = (state == ST_RESP) && r_err;
   assign resp_rdata = (state == ST_RESP && !r_err && !r_write) ? fmt_word : 32'h0;
   assign mwr_valid  = (state == ST_WRITE);
   assign mwr_addr   = {r_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};

endmodule

// File: rtl/scache_checker.sv
module scache_checker #(
   parameter int ADDR_W     = 16,
   parameter int LINE_BYTES = 4096
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_write,
   input logic [1:0]        req_size,
   input logic [ADDR_W-1:0] req_addr,
   input logic              resp_valid,
   input logic              resp_err,
   input logic [31:0]       resp_rdata,
   input logic              mrd_valid,
   input logic              mrd_ready,
   input logic [ADDR_W-1:0] mrd_addr,
   input logic              mwr_valid,
   input logic              mwr_ready,
   input logic [ADDR_W-1:0] mwr_addr,
   input logic [3:0]        mwr_be
);

   localparam int OFS_W = $clog2(LINE_BYTES);
   localparam int WORDS = LINE_BYTES / 4;

   logic        c_write;
   logic [1:0]  c_size;
   logic [1:0]  c_lane;
   logic [31:0] rd_beats;
   logic [31:0] wr_beats;
   logic        c_mis;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_write  <= 1'b0;
         c_size   <= 2'd0;
         c_lane   <= 2'd0;
         rd_beats <= '0;
         wr_beats <= '0;
      end else if (req_valid && req_ready) begin
         c_write  <= req_write;
         c_size   <= req_size;
         c_lane   <= req_addr[1:0];
         rd_beats <= '0;
         wr_beats <= '0;
      end else begin
         if (mrd_valid && mrd_ready) rd_beats <= rd_beats + 1;
         if (mwr_valid && mwr_ready) wr_beats <= wr_beats + 1;
      end
   end

   assign c_mis = (c_size == 2'd1 && c_lane[0]) || (c_size[1] && c_lane != 2'd0);

   AST_RESP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> !req_ready); // R10
   AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid); // R10
   AST_MISALIGN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && c_mis |-> resp_err); // R9
   AST_ERR_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && resp_err |-> rd_beats == 0 && wr_beats == 0); // R9
   AST_FILL_WHOLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && !resp_err && !c_write |-> (rd_beats == 0 || rd_beats == WORDS)); // R3
   AST_FILL_ALIGNED_START: assert property (@(posedge clk) disable iff (!rst_n)
      mrd_valid && rd_beats == 0 |-> mrd_addr[OFS_W-1:0] == '0); // R3
   AST_RGBX_ALPHA: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && !resp_err && !c_write && c_size == 2'd3 |-> resp_rdata[31:24] == 8'hFF); // R5
   AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && !c_write && c_size == 2'd0 |-> resp_rdata[31:8] == 24'h0); // R4
   AST_WRITE_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && c_write && !resp_err |-> wr_beats == 1 && rd_beats == 0); // R6
   AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mwr_valid && !mwr_ready |=> mwr_valid && $stable(mwr_addr) && $stable(mwr_be)); // R6

endmodule

bind span_line_cache scache_checker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (.*);

// File: tb/span_line_cache_test.sv
`timescale 1ns/1ps
module span_line_cache_test;

   localparam int ADDR_W = 16;
   localparam int MWORDS = 2048;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              clear = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_write = 1'b0;
   logic [1:0]        req_size = 2'd0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [31:0]       req_wdata = '0;
   logic              resp_valid;
   logic              resp_err;
   logic [31:0]       resp_rdata;
   logic              mrd_valid;
   logic              mrd_ready;
   logic [ADDR_W-1:0] mrd_addr;
   logic              mrd_rvalid = 1'b0;
   logic [31:0]       mrd_rdata = '0;
   logic              mwr_valid;
   logic              mwr_ready = 1'b0;
   logic [ADDR_W-1:0] mwr_addr;
   logic [31:0]       mwr_data;
   logic [3:0]        mwr_be;

   always #2.5 clk = ~clk;

   span_line_cache #(.ADDR_W(ADDR_W)) uut (.*);

   logic [31:0] mem     [MWORDS];
   logic [31:0] exp_mem [MWORDS];
   logic [1:0]  cyc = 2'd0;
   int          rd_beats = 0;
   int          wr_beats = 0;
   logic        order_bad = 1'b0;
   logic [ADDR_W-1:0] last_rd = '0;
   logic [ADDR_W-1:0] last_waddr = '0;
   logic [31:0] last_wdata = '0;
   logic [3:0]  last_be = '0;
   int          vectors = 0;
   int          misses = 0;
   logic        done = 1'b0;

   assign mrd_ready = (cyc != 2'd3);

   always @(posedge clk) begin
      cyc <= cyc + 2'd1;
      mrd_rvalid <= mrd_valid && mrd_ready;
      if (mrd_valid && mrd_ready) begin
         mrd_rdata <= mem[mrd_addr[12:2]];
         rd_beats  <= rd_beats + 1;
         if (mrd_addr[11:0] != 12'h0 && mrd_addr != last_rd + 16'd4) order_bad <= 1'b1;
         last_rd <= mrd_addr;
      end
      mwr_ready <= mwr_valid && !mwr_ready;
      if (mwr_valid && mwr_ready) begin
         for (int b = 0; b < 4; b++)
            if (mwr_be[b]) mem[mwr_addr[12:2]][8*b +: 8] <= mwr_data[8*b +: 8];
         wr_beats   <= wr_beats + 1;
         last_waddr <= mwr_addr;
         last_wdata <= mwr_data;
         last_be    <= mwr_be;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         misses++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [1:0] size, input logic [15:0] a);
      logic [31:0] w;
      logic [31:0] sh;
      w  = exp_mem[a[12:2]];
      sh = w >> (8 * a[1:0]);
      case (size)
         2'd0:    return {24'h0, sh[7:0]};
         2'd1:    return {16'h0, sh[15:0]};
         2'd2:    return w;
         default: return {8'hFF, w[23:0]};
      endcase
   endfunction

   function automatic logic [3:0] exp_be(input logic [1:0] size, input logic [1:0] lane);
      case (size)
         2'd0:    return 4'b0001 << lane;
         2'd1:    return 4'b0011 << lane;
         2'd2:    return 4'b1111;
         default: return 4'b0111;
      endcase
   endfunction

   // one request through the port; reports data, error, beats and pulse width
   task automatic do_req(input bit wr, input logic [1:0] size, input logic [15:0] a,
                         input logic [31:0] wd, output logic [31:0] rd, output bit err,
                         output int rbeats, output int wbeats, output int plen, output bit busy_ok);
      int r0, w0, guard;
      @(negedge clk);
      r0 = rd_beats; w0 = wr_beats;
      req_valid = 1'b1; req_write = wr; req_size = size; req_addr = a; req_wdata = wd;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      busy_ok = 1'b1;
      guard = 0;
      while (!resp_valid && guard < 5000) begin
         if (req_ready) busy_ok = 1'b0;
         @(negedge clk);
         guard++;
      end
      rd = resp_rdata; err = resp_err;
      plen = 0;
      while (resp_valid) begin plen++; @(negedge clk); end
      rbeats = rd_beats - r0; wbeats = wr_beats - w0;
      if (wr && !err)
         for (int b = 0; b < 4; b++)
            if (exp_be(size, a[1:0])[b]) exp_mem[a[12:2]][8*b +: 8] = (wd << (8 * a[1:0])) >> (8*b);
   endtask

   logic [31:0] rd;
   bit          err;
   bit          bz;
   int          rb, wb, pl;

   task automatic t_reset();
      check(req_ready === 1'b1, "R1 ready after reset", 32'(req_ready), 1);
      check(resp_valid === 1'b0 && mrd_valid === 1'b0 && mwr_valid === 1'b0,
            "R1 outputs idle after reset", {resp_valid, mrd_valid, mwr_valid}, 0);
   endtask

   task automatic t_cold_miss();
      do_req(0, 2'd2, 16'h0010, 0, rd, err, rb, wb, pl, bz);
      check(rb == 1024, "R1 R3 first read fills line", rb, 1024);
      check(!order_bad, "R3 fill ascending from aligned base", 32'(order_bad), 0);
      check(rd == exp_read(2'd2, 16'h0010), "R4 word after miss", rd, exp_read(2'd2, 16'h0010));
   endtask

   task automatic t_hit_sizes();
      do_req(0, 2'd0, 16'h0013, 0, rd, err, rb, wb, pl, bz);
      check(rd == exp_read(2'd0, 16'h0013) && rb == 0, "R2 R4 byte hit", rd, exp_read(2'd0, 16'h0013));
      do_req(0, 2'd1, 16'h0016, 0, rd, err, rb, wb, pl, bz);
      check(rd == exp_read(2'd1, 16'h0016) && rb == 0, "R2 R4 half hit", rd, exp_read(2'd1, 16'h0016));
      do_req(0, 2'd2, 16'h0FFC, 0, rd, err, rb, wb, pl, bz);
      check(rd == exp_read(2'd2, 16'h0FFC) && rb == 0, "R2 R4 last word hit", rd, exp_read(2'd2, 16'h0FFC));
   endtask

   task automatic t_other_line();
      do_req(0, 2'd2, 16'h1008, 0, rd, err, rb, wb, pl, bz);
      check(rb == 1024 && rd == exp_read(2'd2, 16'h1008), "R2 new tag misses", rb, 1024);
      do_req(0, 2'd0, 16'h0005, 0, rd, err, rb, wb, pl, bz);
      check(rb == 1024 && rd == exp_read(2'd0, 16'h0005), "R2 old tag misses again", rb, 1024);
   endtask

   task automatic t_rgbx_read();
      do_req(0, 2'd3, 16'h0020, 0, rd, err, rb, wb, pl, bz);
      check(rd == exp_read(2'd3, 16'h0020) && rd[31:24] == 8'hFF, "R5 no-alpha read", rd, exp_read(2'd3, 16'h0020));
   endtask

   task automatic t_writes();
      do_req(1, 2'd0, 16'h0011, 32'h0000005A, rd, err, rb, wb, pl, bz);
      check(wb == 1 && rb == 0 && last_waddr == 16'h0010 && last_wdata == 32'h00005A00,
            "R6 byte write beat", last_wdata, 32'h00005A00);
      check(last_be == 4'b0010, "R7 byte enables lane 1", 32'(last_be), 32'h2);
      do_req(0, 2'd2, 16'h0010, 0, rd, err, rb, wb, pl, bz);
      check(rb == 1024 && rd == exp_read(2'd2, 16'h0010), "R6 read after write refetches", rd, exp_read(2'd2, 16'h0010));
      do_req(1, 2'd1, 16'h0012, 32'h0000BEEF, rd, err, rb, wb, pl, bz);
      check(last_be == 4'b1100 && last_wdata == 32'hBEEF0000, "R7 half enables lane 2", 32'(last_be), 32'hC);
      do_req(1, 2'd3, 16'h0014, 32'h11223344, rd, err, rb, wb, pl, bz);
      check(last_be == 4'b0111, "R7 no-alpha write enables", 32'(last_be), 32'h7);
      do_req(0, 2'd2, 16'h0014, 0, rd, err, rb, wb, pl, bz);
      check(rd == exp_read(2'd2, 16'h0014), "R7 top byte kept by no-alpha write", rd, exp_read(2'd2, 16'h0014));
      do_req(0, 2'd2, 16'h0010, 0, rd, err, rb, wb, pl, bz);
      check(rb == 0 && rd == exp_read(2'd2, 16'h0010), "R6 merged word after writes", rd, exp_read(2'd2, 16'h0010));
   endtask

   task automatic t_clear();
      int r0, w0;
      do_req(0, 2'd2, 16'h0100, 0, rd, err, rb, wb, pl, bz);
      @(negedge clk);
      r0 = rd_beats; w0 = wr_beats;
      clear = 1'b1;
      @(negedge clk);
      clear = 1'b0;
      repeat (3) @(negedge clk);
      check(rd_beats == r0 && wr_beats == w0, "R8 clear makes no traffic", rd_beats - r0, 0);
      do_req(0, 2'd2, 16'h0100, 0, rd, err, rb, wb, pl, bz);
      check(rb == 1024 && rd == exp_read(2'd2, 16'h0100), "R8 read after clear refetches", rb, 1024);
   endtask

   task automatic t_misalign();
      do_req(0, 2'd1, 16'h0101, 0, rd, err, rb, wb, pl, bz);
      check(err && rb == 0 && wb == 0, "R9 odd half read flagged", 32'(err), 1);
      do_req(1, 2'd2, 16'h0102, 32'hFFFFFFFF, rd, err, rb, wb, pl, bz);
      check(err && rb == 0 && wb == 0, "R9 split word write flagged", 32'(err), 1);
      do_req(0, 2'd3, 16'h0103, 0, rd, err, rb, wb, pl, bz);
      check(err && rb == 0, "R9 split no-alpha read flagged", 32'(err), 1);
      do_req(0, 2'd2, 16'h0104, 0, rd, err, rb, wb, pl, bz);
      check(!err && rb == 0 && rd == exp_read(2'd2, 16'h0104), "R9 line survives errors", rd, exp_read(2'd2, 16'h0104));
   endtask

   task automatic t_handshake();
      do_req(0, 2'd0, 16'h1234, 0, rd, err, rb, wb, pl, bz);
      check(bz && pl == 1, "R10 busy during miss, one-cycle response", pl, 1);
      do_req(1, 2'd2, 16'h1230, 32'hCAFEF00D, rd, err, rb, wb, pl, bz);
      check(bz && pl == 1, "R10 busy during write, one-cycle response", pl, 1);
   endtask

   initial begin
      for (int i = 0; i < MWORDS; i++) begin
         mem[i]     = (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000;
         exp_mem[i] = (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cold_miss();
      t_hit_sizes();
      t_other_line();
      t_rgbx_read();
      t_writes();
      t_clear();
      t_misalign();
      t_handshake();
      repeat (4) @(negedge clk);
      report();
   end

   initial begin
      repeat (150000) @(posedge clk);
      misses++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

endmodule